// File: doc/BRIEF.md
# Segment Address Extension Unit

This unit widens the 32-bit logical addresses issued by a bus master into 36-bit physical addresses. Each privilege ID owns a private set of segment entries. An entry names a power-of-two logical segment through a base and a size code, supplies a replacement for the physical bits above the segment offset, and carries six permission bits. The permission bits cover read, write and execute, each for supervisor and for user.

A lookup presents an address, a privilege ID, an access kind and a supervisor flag. The unit returns the physical address, a hit flag and a permission fault in the same cycle, with no clock edge in the path. When more than one entry matches, the highest-numbered entry wins. Software programs the entries through a simple write port. Each entry is split into a high word (base and size) and a low word (replacement and permissions). A write is visible from the next rising clock edge.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, entry 0 of every privilege ID maps the whole 4 GB logical space onto physical addresses 0x0_00000000 to 0x0_FFFFFFFF unchanged, with all six permissions granted. Every other entry is inactive.
- R2: A write with `cfg_hi`=1 loads base = `cfg_wdata[31:12]` and size code = `cfg_wdata[4:0]`. A write with `cfg_hi`=0 loads replacement = `cfg_wdata[31:8]` and permissions = `cfg_wdata[5:0]`. The new value affects lookups only after the next rising clock edge, never in the cycle of the write.
- R3: The segment size is 2^(code+1) bytes; for example, code 0x1A gives 128 MB. An entry matches when the logical address bits at and above the segment size equal the same bits of the base.
- R4: On a permitted hit, the physical address is the replacement (taken as physical bits 35:12) above the segment offset, joined to the unchanged offset bits. For example, low word 0x8080003F with high word 0x8000001A maps logical 0x80000080 to physical 0x8_08000080.
- R5: An entry whose size code is below 0x0B never matches. Code 0x0B gives a 4 KB segment and does match.
- R6: When several entries of the requesting privilege ID match, the highest-numbered one decides the address and the permission outcome.
- R7: A write to one privilege ID's entries has no effect on the lookups of any other privilege ID.
- R8: The permission bits are: bit 5 supervisor read, bit 4 supervisor write, bit 3 supervisor execute, bit 2 user read, bit 1 user write, bit 0 user execute. The access kinds are: 0 = read, 1 = write, 2 = execute, and 3 = no permission bit at all. On a hit where the selected bit is clear, `xl_fault`=1, `xl_hit`=1 and `xl_phys`=0.
- R9: When no entry matches, `xl_hit`=0, `xl_fault`=0 and `xl_phys`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_priv | input | PRIV_W | Privilege ID whose entry is written |
| cfg_slot | input | ENT_W | Entry number within that set |
| cfg_hi | input | 1 | 1 = high word (base, size), 0 = low word (replacement, permissions) |
| cfg_wdata | input | 32 | Write data |
| req_addr | input | 32 | Logical address of the lookup |
| req_priv | input | PRIV_W | Privilege ID of the lookup |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| req_sup | input | 1 | 1 = supervisor access, 0 = user access |
| xl_phys | output | 36 | Physical address, zero on a miss or a fault |
| xl_hit | output | 1 | Some entry matched |
| xl_fault | output | 1 | The matching entry denies this access |

## Verification
An entry write and a lookup can land in the same cycle, and the lookup may target the very entry being written. The bench provokes this by presenting a high-word write for an entry together with a request that falls in the new segment. It expects the old mapping (the default entry) in that cycle, and the new mapping in the next cycle with the request held steady. A concurrent assertion also requires the outputs to stay constant across an edge when the request is steady and no write took place.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LA_W     = 32;
    localparam int PA_W     = 36;
    localparam int PG_W     = 12;
    localparam int BASE_W   = LA_W - PG_W;
    localparam int REPL_W   = PA_W - PG_W;
    localparam int CODE_W   = 5;
    localparam int PERM_W   = 6;
    localparam int MIN_CODE = PG_W - 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
        logic [REPL_W-1:0] repl;
        logic [PERM_W-1:0] perm;
    } seg_entry_t;

    typedef enum logic [1:0] {
        ACC_RD   = 2'd0,
        ACC_WR   = 2'd1,
        ACC_EX   = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

    function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                         input logic [1:0] kind,
                                         input logic sup);
        logic ok;
        case (acc_kind_e'(kind))
            ACC_RD:  ok = sup ? perm[5] : perm[2];
            ACC_WR:  ok = sup ? perm[4] : perm[1];
            ACC_EX:  ok = sup ? perm[3] : perm[0];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_entry_regs.sv
module seg_entry_regs
    import seg_xlate_pkg::*;
#(
    parameter int NUM_PRIV = 4,
    parameter int NUM_ENT  = 8,
    localparam int PRIV_W  = $clog2(NUM_PRIV),
    localparam int ENT_W   = $clog2(NUM_ENT),
    localparam int TOTAL   = NUM_PRIV * NUM_ENT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [PRIV_W-1:0]        cfg_priv,
    input  logic [ENT_W-1:0]         cfg_slot,
    input  logic                     cfg_hi,
    input  logic [LA_W-1:0]          cfg_wdata,
    output seg_entry_t [TOTAL-1:0]   ents_o
);

    typedef struct packed {
        seg_entry_t [TOTAL-1:0] ent;
    } regs_t;

    function automatic regs_t reset_image();
        regs_t r;
        r = '0;
        for (int p = 0; p < NUM_PRIV; p++) begin
            r.ent[p*NUM_ENT].code = CODE_W'(LA_W - 1);
            r.ent[p*NUM_ENT].perm = '1;
        end
        return r;
    endfunction

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < TOTAL; i++) begin
            if (cfg_we && cfg_priv == PRIV_W'(i / NUM_ENT) &&
                cfg_slot == ENT_W'(i % NUM_ENT)) begin
                if (cfg_hi) begin
                    state_d.ent[i].base = cfg_wdata[LA_W-1:PG_W];
                    state_d.ent[i].code = cfg_wdata[CODE_W-1:0];
                end else begin
                    state_d.ent[i].repl = cfg_wdata[LA_W-1:8];
                    state_d.ent[i].perm = cfg_wdata[PERM_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= reset_image();
        else        state_q <= state_d;
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^cfg_wdata[7:6];

    assign ents_o = state_q.ent;

endmodule

// File: rtl/seg_entry_match.sv
module seg_entry_match
    import seg_xlate_pkg::*;
(
    input  seg_entry_t        ent,
    input  logic [LA_W-1:0]   addr,
    input  logic [1:0]        kind,
    input  logic              sup,
    output logic              hit,
    output logic              allow,
    output logic [PA_W-1:0]   phys
);

    logic [LA_W:0]   span;
    logic [LA_W:0]   span_m1;
    logic [LA_W-1:0] off_m;
    logic [PA_W-1:0] off_m_w;
    logic [LA_W-1:0] base_full;
    logic [PA_W-1:0] repl_full;

    always_comb begin
        span      = (LA_W+1)'(1) << ({1'b0, ent.code} + 6'd1);
        span_m1   = span - (LA_W+1)'(1);
        off_m     = span_m1[LA_W-1:0];
        off_m_w   = {{(PA_W-LA_W){1'b0}}, off_m};
        base_full = {ent.base, {PG_W{1'b0}}};
        repl_full = {ent.repl, {PG_W{1'b0}}};
        hit       = (ent.code >= CODE_W'(MIN_CODE)) &&
                    (((addr ^ base_full) & ~off_m) == '0);
        allow     = perm_allows(ent.perm, kind, sup);
        phys      = (repl_full & ~off_m_w) |
                    ({{(PA_W-LA_W){1'b0}}, addr} & off_m_w);
    end

endmodule

// File: rtl/seg_prio_pick.sv
module seg_prio_pick
    import seg_xlate_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]             hit_v,
    input  logic [N-1:0]             allow_v,
    input  logic [N-1:0][PA_W-1:0]   phys_a,
    output logic                     any_hit,
    output logic                     allow_sel,
    output logic [PA_W-1:0]          phys_sel
);

    always_comb begin
        any_hit   = 1'b0;
        allow_sel = 1'b0;
        phys_sel  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_v[i]) begin
                any_hit   = 1'b1;
                allow_sel = allow_v[i];
                phys_sel  = phys_a[i];
            end
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int NUM_PRIV = 4,
    parameter int NUM_ENT  = 8,
    localparam int PRIV_W  = $clog2(NUM_PRIV),
    localparam int ENT_W   = $clog2(NUM_ENT),
    localparam int TOTAL   = NUM_PRIV * NUM_ENT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PRIV_W-1:0] cfg_priv,
    input  logic [ENT_W-1:0]  cfg_slot,
    input  logic              cfg_hi,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       req_addr,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic [1:0]        req_kind,
    input  logic              req_sup,
    output logic [35:0]       xl_phys,
    output logic              xl_hit,
    output logic              xl_fault
);

    seg_entry_t [TOTAL-1:0]         all_ents;
    seg_entry_t [NUM_ENT-1:0]       set_sel;
    logic [NUM_ENT-1:0]             hit_v;
    logic [NUM_ENT-1:0]             allow_v;
    logic [NUM_ENT-1:0][PA_W-1:0]   phys_a;
    logic                           any_hit;
    logic                           allow_sel;
    logic [PA_W-1:0]                phys_sel;

    seg_entry_regs #(.NUM_PRIV(NUM_PRIV), .NUM_ENT(NUM_ENT)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_priv (cfg_priv),
        .cfg_slot (cfg_slot),
        .cfg_hi   (cfg_hi),
        .cfg_wdata(cfg_wdata),
        .ents_o   (all_ents)
    );

    always_comb begin
        set_sel = '0;
        for (int p = 0; p < NUM_PRIV; p++) begin
            if (req_priv == PRIV_W'(p))
                set_sel = all_ents[p*NUM_ENT +: NUM_ENT];
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_match
        seg_entry_match match_i (
            .ent  (set_sel[e]),
            .addr (req_addr),
            .kind (req_kind),
            .sup  (req_sup),
            .hit  (hit_v[e]),
            .allow(allow_v[e]),
            .phys (phys_a[e])
        );
    end

    seg_prio_pick #(.N(NUM_ENT)) pick_i (
        .hit_v    (hit_v),
        .allow_v  (allow_v),
        .phys_a   (phys_a),
        .any_hit  (any_hit),
        .allow_sel(allow_sel),
        .phys_sel (phys_sel)
    );

    always_comb begin
        xl_hit   = any_hit;
        xl_fault = any_hit && !allow_sel;
        xl_phys  = (any_hit && allow_sel) ? phys_sel : '0;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [31:0]       req_addr,
    input logic [PRIV_W-1:0] req_priv,
    input logic [1:0]        req_kind,
    input logic              req_sup,
    input logic [35:0]       xl_phys,
    input logic              xl_hit,
    input logic              xl_fault
);

    // R8: a fault is only ever raised on a matching entry
    p_fault_has_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> xl_hit);

    // R9 and R8: no address leaves the unit on a miss or a fault
    p_quiet_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xl_hit || xl_fault) |-> (xl_phys == 36'd0));

    // R4: the smallest segment is 4 KB, so the page offset always passes through
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_hit && !xl_fault) |-> (xl_phys[11:0] == req_addr[11:0]));

    // R2: without a write at the previous edge, a steady request gives a steady result
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_we) && $stable(req_addr) && $stable(req_priv) &&
         $stable(req_kind) && $stable(req_sup))
        |-> ($stable(xl_phys) && $stable(xl_hit) && $stable(xl_fault)));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.PRIV_W(PRIV_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .req_addr(req_addr),
    .req_priv(req_priv),
    .req_kind(req_kind),
    .req_sup (req_sup),
    .xl_phys (xl_phys),
    .xl_hit  (xl_hit),
    .xl_fault(xl_fault)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_priv = '0;
    logic [2:0]  cfg_slot = '0;
    logic        cfg_hi = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_priv = '0;
    logic [1:0]  req_kind = '0;
    logic        req_sup = 1'b0;
    logic [35:0] xl_phys;
    logic        xl_hit;
    logic        xl_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_priv (cfg_priv),
        .cfg_slot (cfg_slot),
        .cfg_hi   (cfg_hi),
        .cfg_wdata(cfg_wdata),
        .req_addr (req_addr),
        .req_priv (req_priv),
        .req_kind (req_kind),
        .req_sup  (req_sup),
        .xl_phys  (xl_phys),
        .xl_hit   (xl_hit),
        .xl_fault (xl_fault)
    );

    typedef struct {
        logic [35:0] phys;
        logic        hit;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2, NONE = 2'd3;

    task automatic push_exp(input logic [35:0] p, input logic h, input logic f,
                            input string tag);
        exp_t it;
        it.phys = p; it.hit = h; it.fault = f; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic cfg_write(input logic [1:0] pr, input logic [2:0] sl,
                             input logic hi, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = pr; cfg_slot = sl; cfg_hi = hi; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] pr, input logic [31:0] a,
                          input logic [1:0] k, input logic s,
                          input logic [35:0] ep, input logic eh, input logic ef,
                          input string tag);
        @(negedge clk);
        req_priv = pr; req_addr = a; req_kind = k; req_sup = s;
        push_exp(ep, eh, ef, tag);
    endtask

    // monitor: one comparison per cycle, well before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                total++;
                if (xl_phys !== it.phys || xl_hit !== it.hit || xl_fault !== it.fault) begin
                    bad++;
                    $display("FAIL %s: got phys=%h hit=%b fault=%b, expected phys=%h hit=%b fault=%b",
                             it.tag, xl_phys, xl_hit, xl_fault, it.phys, it.hit, it.fault);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: default entry 0, identity mapping, all permissions
        lookup(0, 32'h1234_5678, RD, 1, 36'h0_1234_5678, 1, 0, "R1 priv0 default");
        lookup(3, 32'hFFFF_FFFC, EX, 0, 36'h0_FFFF_FFFC, 1, 0, "R1 priv3 default");

        // R3/R4: 128 MB segment at 0x80000000 -> 0x8_08000000 in priv1 entry 1
        cfg_write(1, 1, 1'b0, 32'h8080_003F);
        cfg_write(1, 1, 1'b1, 32'h8000_001A);
        lookup(1, 32'h8000_0000, RD, 1, 36'h8_0800_0000, 1, 0, "R4 segment start");
        lookup(1, 32'h8000_0080, WR, 0, 36'h8_0800_0080, 1, 0, "R4 offset 0x80");
        lookup(1, 32'h87FF_FFFF, RD, 0, 36'h8_0FFF_FFFF, 1, 0, "R3 last byte");
        lookup(1, 32'h8800_0000, RD, 0, 36'h0_8800_0000, 1, 0, "R3 past segment");
        lookup(2, 32'h8000_0080, RD, 0, 36'h0_8000_0080, 1, 0, "R7 other priv");

        // R2: write high word and look up in the same cycle
        cfg_write(1, 2, 1'b0, 32'hABC0_003F);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1; cfg_slot = 2; cfg_hi = 1'b1; cfg_wdata = 32'h4000_0018;
        req_priv = 1; req_addr = 32'h4000_0100; req_kind = RD; req_sup = 1;
        push_exp(36'h0_4000_0100, 1, 0, "R2 old map in write cycle");
        @(negedge clk);
        cfg_we = 1'b0;
        push_exp(36'hA_BC00_0100, 1, 0, "R2 new map next cycle");

        // R6: 1 MB entry 3 inside entry 1's segment
        cfg_write(1, 3, 1'b0, 32'h1230_003F);
        cfg_write(1, 3, 1'b1, 32'h8010_0013);
        lookup(1, 32'h8010_0040, RD, 1, 36'h1_2300_0040, 1, 0, "R6 entry3 over entry1");
        lookup(1, 32'h8020_0040, RD, 1, 36'h8_0820_0040, 1, 0, "R6 entry1 outside entry3");
        cfg_write(1, 5, 1'b0, 32'h3000_003F);
        cfg_write(1, 5, 1'b1, 32'h8000_001A);
        lookup(1, 32'h8010_0040, RD, 1, 36'h3_0010_0040, 1, 0, "R6 entry5 over entry3");

        // R5 / R9: reserved code, default entry disabled
        cfg_write(2, 4, 1'b0, 32'h5550_003F);
        cfg_write(2, 4, 1'b1, 32'h9000_000A);
        lookup(2, 32'h9000_0010, RD, 1, 36'h0_9000_0010, 1, 0, "R5 code 0x0A ignored");
        cfg_write(2, 0, 1'b1, 32'h0000_0000);
        lookup(2, 32'h9000_0010, RD, 1, 36'h0, 0, 0, "R9 no entry matches");
        cfg_write(2, 4, 1'b1, 32'h9000_000B);
        lookup(2, 32'h9000_0010, RD, 1, 36'h5_5500_0010, 1, 0, "R5 code 0x0B hits");
        lookup(2, 32'h9000_0FFF, RD, 1, 36'h5_5500_0FFF, 1, 0, "R5 4KB last byte");
        lookup(2, 32'h9000_1000, RD, 1, 36'h0, 0, 0, "R9 past 4KB");

        // R8: permissions, bit5 sup rd .. bit0 user ex
        cfg_write(3, 6, 1'b0, 32'h7770_0020);
        cfg_write(3, 6, 1'b1, 32'hC000_0014);
        lookup(3, 32'hC000_0004, RD, 1, 36'h7_7700_0004, 1, 0, "R8 sup read allowed");
        lookup(3, 32'hC000_0004, WR, 1, 36'h0, 1, 1, "R8 sup write denied");
        lookup(3, 32'hC000_0004, RD, 0, 36'h0, 1, 1, "R8 user read denied");
        lookup(3, 32'hC000_0004, NONE, 1, 36'h0, 1, 1, "R8 kind 3 denied");
        cfg_write(3, 6, 1'b0, 32'h7770_0009);
        lookup(3, 32'hC000_0008, EX, 0, 36'h7_7700_0008, 1, 0, "R8 user exec allowed");
        lookup(3, 32'hC000_0008, EX, 1, 36'h7_7700_0008, 1, 0, "R8 sup exec allowed");
        lookup(3, 32'hC000_0008, WR, 0, 36'h0, 1, 1, "R8 user write denied");
        lookup(0, 32'hC000_0004, WR, 0, 36'h0_C000_0004, 1, 0, "R7 priv0 untouched");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule